// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits on the cartridge side of an 8K-address CPU bus and maps a 4K window at system addresses $1000–$1FFF onto a large external ROM and a smaller external RAM. The window is split into two 2K halves. The upper half ($1800–$1FFF) is wired permanently to the last ROM bank, so reset vectors and the switching code stay visible. The lower half ($1000–$17FF) shows either a ROM bank or a RAM bank.

No register of its own is exposed in the window. The mapper instead watches CPU writes to two zero-page addresses that fall in the video chip's decode region but are not used by it. A write to $3F picks a 2K ROM bank from the data byte. A write to $3E picks a 1K RAM bank. While RAM is selected, the first 1K of the lower half is the RAM read port and the second 1K is its write port. The block treats each clock as one bus cycle. It drives addresses and enables for the external arrays from the current address and the latched selection.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the lower half shows ROM bank 0 and RAM is not selected.
- R2: A read with A12=1 and A11=1 asserts rom_rd with rom_addr = (ROM_BANKS-1)*2048 + A[10:0], whatever the selection.
- R3: A write whose address has A12=0, A7=0, A6=0 and A[5:0]=6'b111111 latches the data byte as ROM bank. Any A8–A11 value is accepted. Afterwards a read with A12=1, A11=0 in ROM mode asserts rom_rd with rom_addr = bank*2048 + A[10:0].
- R4: The latched ROM bank is the data byte modulo ROM_BANKS, and the latched RAM bank is the data byte modulo RAM_BANKS.
- R5: A write to the same decode with A[5:0]=6'b111110 latches the RAM bank and switches the lower half to RAM mode.
- R6: In RAM mode, a read with A12=1, A11=0, A10=0 asserts ram_rd with ram_addr = rambank*1024 + A[9:0], and no ROM enable.
- R7: In RAM mode, a write with A12=1, A11=0, A10=1 asserts ram_wr with the same address form. Reads of that quarter and writes to the read quarter assert no enable.
- R8: A write to the ROM hotspot returns the lower half to ROM mode.
- R9: A hotspot read, or a write with A7=1, A6=1 or A12=1, changes no selection.
- R10: With A12=0 no enable is asserted. A write never asserts rom_rd. At most one of rom_rd, ram_rd and ram_wr is high.
- R11: A selection written in one cycle governs the access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 13 | CPU address A12..A0 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_data | input | 8 | CPU write data, snooped at hotspots |
| rom_addr | output | ROM_AW | External ROM address |
| rom_rd | output | 1 | External ROM read enable |
| ram_addr | output | RAM_AW | External RAM address |
| ram_rd | output | 1 | External RAM read enable |
| ram_wr | output | 1 | External RAM write enable |

## Verification
A selection update and the first access that depends on it meet at one clock edge. The hotspot write is latched at the same edge that ends its bus cycle. The next cycle's fetch must already see the new bank or mode. The bench provokes this with hotspot writes followed directly by lower-half accesses, including a RAM select and a ROM select back to back. Each result is judged against a behavioural model that updates its bank state only after comparing the current cycle.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int ROM_BANKS = 6,
  parameter int RAM_BANKS = 4,
  localparam int RBW    = $clog2(ROM_BANKS),
  localparam int MBW    = $clog2(RAM_BANKS),
  localparam int ROM_AW = RBW + 11,
  localparam int RAM_AW = MBW + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [12:0]       cpu_addr,
  input  logic              cpu_rw,
  input  logic [7:0]        cpu_data,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_wr
);
  localparam logic [RBW-1:0] LAST = RBW'(ROM_BANKS - 1);

  logic [RBW-1:0] rom_bank;
  logic [MBW-1:0] ram_bank;
  logic           ram_mode;

  wire wr_cyc  = !cpu_rw;
  wire zp_hot  = !cpu_addr[12] && !cpu_addr[7] && !cpu_addr[6] && (cpu_addr[5:1] == 5'b11111);
  wire sel_rom = zp_hot && wr_cyc && cpu_addr[0];
  wire sel_ram = zp_hot && wr_cyc && !cpu_addr[0];
  wire upper   = cpu_addr[12] && cpu_addr[11];
  wire lower   = cpu_addr[12] && !cpu_addr[11];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= '0;
      ram_bank <= '0;
      ram_mode <= 1'b0;
    end else if (sel_rom) begin
      rom_bank <= RBW'({1'b0, cpu_data} % 9'(ROM_BANKS));
      ram_mode <= 1'b0;
    end else if (sel_ram) begin
      ram_bank <= MBW'({1'b0, cpu_data} % 9'(RAM_BANKS));
      ram_mode <= 1'b1;
    end
  end

  assign rom_rd   = cpu_rw && (upper || (lower && !ram_mode));
  assign ram_rd   = cpu_rw && lower && ram_mode && !cpu_addr[10];
  assign ram_wr   = wr_cyc && lower && ram_mode && cpu_addr[10];
  assign rom_addr = {upper ? LAST : rom_bank, cpu_addr[10:0]};
  assign ram_addr = {ram_bank, cpu_addr[9:0]};
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int ROM_BANKS = 6,
  parameter int RAM_BANKS = 4,
  localparam int RBW    = $clog2(ROM_BANKS),
  localparam int MBW    = $clog2(RAM_BANKS),
  localparam int ROM_AW = RBW + 11,
  localparam int RAM_AW = MBW + 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [12:0]       cpu_addr,
  input logic              cpu_rw,
  input logic [7:0]        cpu_data,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_rd,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_rd,
  input logic              ram_wr
);
  logic hot_rom_w, hot_ram_w, in_ram, lo_half;
  assign hot_rom_w = !cpu_rw && cpu_addr[12:6] == 7'b0 && cpu_addr[5:0] == 6'h3F
                     || !cpu_rw && !cpu_addr[12] && !cpu_addr[7] && !cpu_addr[6] && cpu_addr[5:0] == 6'h3F;
  assign hot_ram_w = !cpu_rw && !cpu_addr[12] && !cpu_addr[7] && !cpu_addr[6] && cpu_addr[5:0] == 6'h3E;
  assign lo_half   = cpu_addr[12:11] == 2'b10;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_ram <= 1'b0;
    else if (hot_rom_w) in_ram <= 1'b0;
    else if (hot_ram_w) in_ram <= 1'b1;

  p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rw && cpu_addr[12:11] == 2'b11) |->
      (rom_rd && int'(rom_addr[ROM_AW-1:11]) == ROM_BANKS - 1 && rom_addr[10:0] == cpu_addr[10:0]));

  p_idle_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[12] |-> !(rom_rd || ram_rd || ram_wr));

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd, ram_rd, ram_wr}) && !(rom_rd && !cpu_rw));

  p_ram_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && lo_half && cpu_rw && !cpu_addr[10]) |->
      (ram_rd && !rom_rd && ram_addr[9:0] == cpu_addr[9:0]));

  p_ram_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && lo_half && !cpu_rw && cpu_addr[10]) |-> (ram_wr && ram_addr[9:0] == cpu_addr[9:0]));

  p_rom_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hot_rom_w) && lo_half && cpu_rw) |-> (rom_rd && !ram_rd));

  p_bank_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hot_rom_w) && lo_half && cpu_rw) |->
      (int'(rom_addr[ROM_AW-1:11]) == int'($past(cpu_data)) % ROM_BANKS));

  p_ram_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hot_ram_w) && lo_half && cpu_rw && !cpu_addr[10]) |->
      (ram_rd && int'(ram_addr[RAM_AW-1:10]) == int'($past(cpu_data)) % RAM_BANKS));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_chk (.*);

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
  localparam int ROM_BANKS = 6;
  localparam int RAM_BANKS = 4;
  localparam int ROM_AW = $clog2(ROM_BANKS) + 11;
  localparam int RAM_AW = $clog2(RAM_BANKS) + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] cpu_addr = 13'h0080;
  logic cpu_rw = 1'b1;
  logic [7:0] cpu_data = 8'h00;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] ram_addr;
  logic rom_rd, ram_rd, ram_wr;

  int vectors = 0, miscompares = 0;
  int m_rom = 0, m_ram = 0;
  bit m_rammode = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cart_bank_mapper #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_data(cpu_data),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr));

  task automatic apply(input int a, input bit rd, input int d, input string req);
    bit e_rom, e_rrd, e_rwr, hot;
    int e_raddr, e_maddr;
    @(negedge clk);
    cpu_addr = 13'(a); cpu_rw = rd; cpu_data = 8'(d);
    #1;
    e_rom = 0; e_rrd = 0; e_rwr = 0; e_raddr = 0; e_maddr = 0;
    if (a >= 'h1800 && rd) begin e_rom = 1; e_raddr = (ROM_BANKS - 1) * 2048 + (a % 2048); end
    else if (a >= 'h1000 && a < 'h1800) begin
      if (!m_rammode) begin e_rom = rd; e_raddr = m_rom * 2048 + (a % 2048); end
      else if ((a % 2048) < 1024) begin e_rrd = rd; e_maddr = m_ram * 1024 + (a % 1024); end
      else begin e_rwr = !rd; e_maddr = m_ram * 1024 + (a % 1024); end
    end
    vectors++;
    if (rom_rd !== e_rom || ram_rd !== e_rrd || ram_wr !== e_rwr ||
        (e_rom && int'(rom_addr) != e_raddr) || ((e_rrd || e_rwr) && int'(ram_addr) != e_maddr)) begin
      miscompares++;
      $display("FAIL %s addr=%h rw=%0d: got rom_rd=%0d ram_rd=%0d ram_wr=%0d rom_addr=%h ram_addr=%h, expected %0d %0d %0d %h %h",
               req, a, rd, rom_rd, ram_rd, ram_wr, rom_addr, ram_addr, e_rom, e_rrd, e_rwr, e_raddr, e_maddr);
    end
    @(posedge clk);
    hot = !rd && a < 'h1000 && (a % 256) < 'h40 && (a % 64) >= 'h3E;
    if (hot && (a % 2) == 1) begin m_rom = d % ROM_BANKS; m_rammode = 0; end
    else if (hot) begin m_ram = d % RAM_BANKS; m_rammode = 1; end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    apply('h1000, 1, 0, "R1"); apply('h17FF, 1, 0, "R1"); apply('h1400, 1, 0, "R1");
    apply('h1800, 1, 0, "R2"); apply('h1FFF, 1, 0, "R2"); apply('h1ABC, 1, 0, "R2");
    apply('h003F, 0, 3, "R3"); apply('h1234, 1, 0, "R3");
    apply('h0F3F, 0, 5, "R3"); apply('h1001, 1, 0, "R3");
    apply('h003F, 0, 6, "R4"); apply('h1002, 1, 0, "R4");
    apply('h053F, 0, 255, "R4"); apply('h1003, 1, 0, "R4");
    apply('h003F, 0, 13, "R4"); apply('h1004, 1, 0, "R4");
    apply('h00BF, 0, 2, "R9"); apply('h1005, 1, 0, "R9");
    apply('h007F, 0, 2, "R9"); apply('h1006, 1, 0, "R9");
    apply('h103F, 0, 2, "R9"); apply('h1007, 1, 0, "R9");
    apply('h003F, 1, 2, "R9"); apply('h1008, 1, 0, "R9");
    apply('h003E, 0, 6, "R5"); apply('h1000, 1, 0, "R6"); apply('h13FF, 1, 0, "R6");
    apply('h1400, 0, 9, "R7"); apply('h17FF, 0, 9, "R7");
    apply('h1500, 1, 0, "R7"); apply('h1200, 0, 9, "R7"); apply('h1C00, 1, 0, "R2");
    apply('h033E, 0, 7, "R5"); apply('h1010, 1, 0, "R5");
    apply('h003F, 0, 2, "R8"); apply('h1100, 1, 0, "R8"); apply('h1500, 0, 1, "R8");
    apply('h0280, 1, 0, "R10"); apply('h0080, 0, 1, "R10"); apply('h1900, 0, 1, "R10");
    apply('h003E, 0, 1, "R11"); apply('h1020, 1, 0, "R11");
    apply('h003F, 0, 4, "R11"); apply('h1020, 1, 0, "R11");
    apply('h003E, 0, 3, "R11"); apply('h003F, 0, 1, "R11"); apply('h1030, 1, 0, "R11");
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 5);
      int a;
      case (sel)
        0: a = $urandom_range(0, 15) * 256 + $urandom_range(0, 3) * 64 + 'h3E + $urandom_range(0, 1);
        1: a = $urandom_range('h1000, 'h17FF);
        2: a = $urandom_range('h1800, 'h1FFF);
        3: a = $urandom_range(0, 'h0FFF);
        default: a = $urandom_range('h1000, 'h17FF);
      endcase
      apply(a, 1'($urandom_range(0, 1)), $urandom_range(0, 255), "R11");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule